// File: doc/BRIEF.md
# Pseudo-SRAM Hidden-Refresh Controller

This block is the control core of a pseudo-static memory. Its host side looks like a plain static RAM: a chip select, a write strobe, an output enable, an address and a data bus. Behind that interface the storage behaves like a dynamic array. Each row loses its contents unless it is refreshed within a retention window. The controller keeps the array alive without the host seeing it. Every accepted host command runs as two internal slots. The first slot is reserved for refresh. The second slot performs the read or the write. Refresh therefore never delays a command beyond its fixed length. When no command arrives, a due refresh is done in an idle cycle instead.

A separate active-low power pin, `sleep_n`, puts the block into deep power-down. While it is low, refresh is stopped and every stored word is given up. When the pin returns high, the block waits a fixed number of wake cycles before it accepts commands again. Reads of words lost this way, or of words never written, return a recognisable poison value.

Handshake: `ready` is the acceptance signal. A command is taken at a rising clock edge where `sel_n` is low, `ready` is high and `sleep_n` is high. The host keeps its command on the pins until it sees `ready` high. A low `sel_n` while `ready` is low is not stored. Read data has no back-pressure: `rvalid` is a single-cycle strobe, and the host must capture `rdata` in that cycle.

Top module: `psram_hidden_refresh`

## Requirements
- R1: After reset, `ready` is 1 and `rvalid` is 0.
- R2: A read command (`wr_n`=1, `oe_n`=0) makes `rvalid` high for exactly one cycle, two clock edges after the accepting edge. In that cycle `rdata` carries the last word written to that address.
- R3: Each accepted command holds `ready` low for exactly two cycles (one refresh slot, one access slot). `ready` is high again after the second edge, so back-to-back commands complete once every three cycles.
- R4: A write command (`wr_n`=0) stores `wdata` at `addr` and produces no `rvalid`.
- R5: A stored word survives any stretch without host traffic, because due refreshes are serviced in idle cycles.
- R6: Under uninterrupted back-to-back traffic, due refreshes are serviced in the refresh slots. The refresh row counter wraps over all rows. Stored words stay intact, and a due refresh is held as a single pending flag.
- R7: The clock edge that samples `sleep_n` low drives `ready` low and stops refresh. Afterwards every word reads back as the poison value (default 16'hDEAD).
- R8: After `sleep_n` returns high, `ready` stays low for exactly WAKE_CYCLES cycles (default 8), counted from the first edge that samples `sleep_n` high.
- R9: If `sleep_n` falls while a command is in flight, the command is abandoned: no `rvalid` is produced and the block stays usable after wake-up.
- R10: A read of a word never written returns the poison value.
- R11: A command with `wr_n`=1 and `oe_n`=1 uses both slots but produces no `rvalid` and changes no data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_n | input | 1 | Active-low deep power-down request |
| sel_n | input | 1 | Active-low chip select (command valid) |
| wr_n | input | 1 | Active-low write strobe |
| oe_n | input | 1 | Active-low output enable for reads |
| addr | input | AW (5) | Word address; upper bits select the row |
| wdata | input | DW (16) | Write data |
| ready | output | 1 | Command can be accepted this cycle |
| rdata | output | DW (16) | Read data, valid while `rvalid` is high |
| rvalid | output | 1 | One-cycle read data strobe |

## Verification
A fault in the refresh timer, the pending flag or the row counter does not show at the ports right away. It shows as poison read back from a word that was written correctly. That happens once the retention window of the neglected row has expired, which is a few hundred cycles with the default parameters. The bench therefore holds data across long idle and long saturated stretches before reading it back. A wrong sequencer state shows within one command: `ready` does not drop for exactly two cycles, `rvalid` arrives at the wrong edge, or a read aborted by power-down still returns data. A wrong wake counter shows as a miscounted low stretch on `ready`.

// File: rtl/psram_pkg.sv
package psram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_REF   = 3'd1,
    ST_ACC   = 3'd2,
    ST_SLEEP = 3'd3,
    ST_WAKE  = 3'd4
  } seq_state_e;

endpackage

// File: rtl/psram_ref_timer.sv
module psram_ref_timer #(
  parameter int INTERVAL = 16,
  parameter int ROWS     = 8,
  localparam int TW      = (INTERVAL > 1) ? $clog2(INTERVAL) : 1,
  localparam int RW      = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          take,
  output logic          pending,
  output logic [RW-1:0] row
);

  logic [TW-1:0] tick;
  logic          tick_wrap;

  assign tick_wrap = (tick == TW'(INTERVAL - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick    <= '0;
      pending <= 1'b0;
      row     <= '0;
    end else if (!run) begin
      tick    <= '0;
      pending <= 1'b0;
    end else begin
      tick    <= tick_wrap ? '0 : tick + 1'b1;
      pending <= tick_wrap | (pending & ~take);
      if (take && pending)
        row <= (row == RW'(ROWS - 1)) ? '0 : row + 1'b1;
    end
  end

  AST_ROW_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && take && pending && row == RW'(ROWS - 1)) |=> (row == '0)); // R6

  AST_NO_PENDING_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !pending); // R7

endmodule

// File: rtl/psram_cell_array.sv
module psram_cell_array #(
  parameter int          ROWS   = 8,
  parameter int          COLS   = 4,
  parameter int          DW     = 16,
  parameter int          RETAIN = 256,
  parameter logic [DW-1:0] POISON = 16'hDEAD,
  localparam int WORDS = ROWS * COLS,
  localparam int AW    = $clog2(WORDS),
  localparam int CW    = $clog2(COLS),
  localparam int RW    = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int AGW   = $clog2(RETAIN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          awake,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          ref_en,
  input  logic [RW-1:0] ref_row,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0]   mem    [WORDS];
  logic            wvalid [WORDS];
  logic [ROWS-1:0] row_lost;
  logic [RW-1:0]   acc_row;

  assign acc_row = addr[AW-1:CW];

  for (genvar g = 0; g < ROWS; g++) begin : g_row
    logic [AGW-1:0] age;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        age <= '0;
      else if (!awake)
        age <= '0;
      else if ((ref_en && ref_row == RW'(g)) || (wr_en && acc_row == RW'(g)))
        age <= '0;
      else if (age != AGW'(RETAIN - 1))
        age <= age + 1'b1;
    end
    assign row_lost[g] = (age == AGW'(RETAIN - 1));
  end

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        wvalid[w] <= 1'b0;
      else if (!awake)
        wvalid[w] <= 1'b0;
      else if (wr_en && addr == AW'(w))
        wvalid[w] <= 1'b1;
      else if (row_lost[w / COLS])
        wvalid[w] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en)
      mem[addr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rdata <= POISON;
    else if (rd_en)
      rdata <= wvalid[addr] ? mem[addr] : POISON;
  end

  AST_ROW_RETAINED: assert property (@(posedge clk) disable iff (!rst_n)
    awake |-> (row_lost == '0)); // R5

endmodule

// File: rtl/psram_seq.sv
module psram_seq
  import psram_pkg::*;
#(
  parameter int WAKE_CYCLES = 8,
  localparam int WCW = $clog2(WAKE_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_n,
  input  logic sel_n,
  input  logic wr_n,
  input  logic oe_n,
  input  logic pending,
  output logic ready,
  output logic accept,
  output logic awake,
  output logic timer_run,
  output logic ref_take,
  output logic acc_wr,
  output logic acc_rd,
  output logic rvalid
);

  seq_state_e     state;
  logic [WCW-1:0] wcnt;
  logic           is_wr;
  logic           is_rd;

  assign ready     = (state == ST_IDLE);
  assign accept    = ready && !sel_n && sleep_n;
  assign awake     = (state != ST_SLEEP);
  assign timer_run = awake && sleep_n;
  assign ref_take  = sleep_n && pending &&
                     ((state == ST_REF) || (state == ST_IDLE && !accept));
  assign acc_wr    = sleep_n && (state == ST_ACC) && is_wr;
  assign acc_rd    = sleep_n && (state == ST_ACC) && is_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      wcnt   <= '0;
      is_wr  <= 1'b0;
      is_rd  <= 1'b0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= acc_rd;
      if (!sleep_n) begin
        state <= ST_SLEEP;
      end else begin
        unique case (state)
          ST_IDLE: if (accept) begin
            state <= ST_REF;
            is_wr <= !wr_n;
            is_rd <= wr_n && !oe_n;
          end
          ST_REF:  state <= ST_ACC;
          ST_ACC:  state <= ST_IDLE;
          ST_SLEEP: begin
            state <= ST_WAKE;
            wcnt  <= '0;
          end
          ST_WAKE: begin
            if (wcnt == WCW'(WAKE_CYCLES - 1))
              state <= ST_IDLE;
            else
              wcnt <= wcnt + 1'b1;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  AST_ACC_FOLLOWS_REF: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ACC) |-> ($past(state) == ST_REF)); // R3

  AST_RVALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |=> !rvalid); // R2

  AST_SLEEP_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_n |=> !ready); // R7

  AST_NO_ACCESS_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_n |-> !(acc_wr || acc_rd)); // R9

endmodule

// File: rtl/psram_hidden_refresh.sv
module psram_hidden_refresh #(
  parameter int            ROWS          = 8,
  parameter int            COLS          = 4,
  parameter int            DW            = 16,
  parameter int            REF_INTERVAL  = 16,
  parameter int            RETAIN_CYCLES = 256,
  parameter int            WAKE_CYCLES   = 8,
  parameter logic [DW-1:0] POISON        = 16'hDEAD,
  localparam int AW = $clog2(ROWS * COLS),
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sleep_n,
  input  logic          sel_n,
  input  logic          wr_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          ready,
  output logic [DW-1:0] rdata,
  output logic          rvalid
);

  logic          accept, awake, timer_run, ref_take, pending;
  logic          acc_wr, acc_rd;
  logic [RW-1:0] ref_row;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] cmd_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_addr  <= '0;
      cmd_wdata <= '0;
    end else if (accept) begin
      cmd_addr  <= addr;
      cmd_wdata <= wdata;
    end
  end

  psram_seq #(.WAKE_CYCLES(WAKE_CYCLES)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .sleep_n  (sleep_n),
    .sel_n    (sel_n),
    .wr_n     (wr_n),
    .oe_n     (oe_n),
    .pending  (pending),
    .ready    (ready),
    .accept   (accept),
    .awake    (awake),
    .timer_run(timer_run),
    .ref_take (ref_take),
    .acc_wr   (acc_wr),
    .acc_rd   (acc_rd),
    .rvalid   (rvalid)
  );

  psram_ref_timer #(.INTERVAL(REF_INTERVAL), .ROWS(ROWS)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (timer_run),
    .take   (ref_take),
    .pending(pending),
    .row    (ref_row)
  );

  psram_cell_array #(
    .ROWS(ROWS), .COLS(COLS), .DW(DW), .RETAIN(RETAIN_CYCLES), .POISON(POISON)
  ) u_array (
    .clk    (clk),
    .rst_n  (rst_n),
    .awake  (awake),
    .wr_en  (acc_wr),
    .rd_en  (acc_rd),
    .addr   (cmd_addr),
    .wdata  (cmd_wdata),
    .ref_en (ref_take),
    .ref_row(ref_row),
    .rdata  (rdata)
  );

  AST_TAKE_ONLY_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    ref_take |-> pending); // R6

  AST_ACCEPT_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !ready); // R3

endmodule

// File: tb/sim_psram_hidden_refresh.sv
module sim_psram_hidden_refresh;

  localparam int          DW   = 16;
  localparam int          AW   = 5;
  localparam int          WAKE = 8;
  localparam logic [15:0] POIS = 16'hDEAD;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sleep_n = 1'b1;
  logic          sel_n = 1'b1;
  logic          wr_n = 1'b1;
  logic          oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          ready, rvalid;
  logic [DW-1:0] rdata;

  always #2 clk = ~clk;

  psram_hidden_refresh #(
    .ROWS(8), .COLS(4), .DW(DW), .REF_INTERVAL(16), .RETAIN_CYCLES(256),
    .WAKE_CYCLES(WAKE), .POISON(POIS)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .sleep_n(sleep_n), .sel_n(sel_n), .wr_n(wr_n),
    .oe_n(oe_n), .addr(addr), .wdata(wdata), .ready(ready), .rdata(rdata),
    .rvalid(rvalid)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [DW-1:0] exp_q[$];
  string         tag_q[$];
  logic [DW-1:0] img [8];

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor: pops the scoreboard whenever read data is strobed
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9_R11_R4", "unexpected rvalid", 1, 0);
      end else begin
        automatic logic [DW-1:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(rdata == e, t, "read data", int'(rdata), int'(e));
      end
    end
  end

  task automatic issue(bit w, bit o, logic [AW-1:0] a, logic [DW-1:0] d);
    while (!ready) @(negedge clk);
    sel_n = 1'b0; wr_n = !w; oe_n = !o; addr = a; wdata = d;
    @(negedge clk);
    sel_n = 1'b1; wr_n = 1'b1; oe_n = 1'b1;
    check(ready == 1'b0, "R3", "ready after accept", int'(ready), 0);
    @(negedge clk);
    check(ready == 1'b0, "R3", "ready in access slot", int'(ready), 0);
    @(negedge clk);
    check(ready == 1'b1, "R3", "ready after two slots", int'(ready), 1);
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
    issue(1'b1, 1'b0, a, d);
  endtask

  task automatic rd(logic [AW-1:0] a, logic [DW-1:0] e, string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    issue(1'b0, 1'b1, a, '0);
  endtask

  function automatic logic [AW-1:0] addr_of(int i);
    return AW'(i * 4 + (i % 4));
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(ready == 1'b1, "R1", "ready after reset", int'(ready), 1);
    check(rvalid == 1'b0, "R1", "rvalid after reset", int'(rvalid), 0);

    rd(5'd5, POIS, "R10");

    for (int i = 0; i < 8; i++) begin
      img[i] = 16'h1000 + 16'(i) * 16'h0111;
      wr(addr_of(i), img[i]);   // R4
    end
    for (int i = 0; i < 8; i++) rd(addr_of(i), img[i], "R2");

    issue(1'b0, 1'b0, 5'd3, '0);  // R11: neither strobe, no rvalid
    rd(5'd3, POIS, "R11");

    repeat (1500) @(negedge clk);
    for (int i = 0; i < 8; i++) rd(addr_of(i), img[i], "R5");

    for (int k = 0; k < 200; k++) rd(addr_of(0), img[0], "R6");
    for (int i = 1; i < 8; i++) rd(addr_of(i), img[i], "R6");

    // deep power-down
    sleep_n = 1'b0;
    @(negedge clk);
    check(ready == 1'b0, "R7", "ready in power-down", int'(ready), 0);
    repeat (300) @(negedge clk);
    sleep_n = 1'b1;
    begin
      automatic int lows = 0;
      @(negedge clk);
      while (!ready && lows < 100) begin
        lows++;
        @(negedge clk);
      end
      check(lows == WAKE, "R8", "wake low cycles", lows, WAKE);
    end
    rd(addr_of(0), POIS, "R7");
    rd(addr_of(4), POIS, "R7");

    // abort an in-flight read with power-down
    wr(5'd2, 16'hBEEF);
    while (!ready) @(negedge clk);
    sel_n = 1'b0; wr_n = 1'b1; oe_n = 1'b0; addr = 5'd2;
    @(negedge clk);
    sel_n = 1'b1; oe_n = 1'b1;
    sleep_n = 1'b0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check(rvalid == 1'b0, "R9", "rvalid after abort", int'(rvalid), 0);
    end
    sleep_n = 1'b1;
    rd(5'd2, POIS, "R9");
    wr(5'd2, 16'h1234);
    rd(5'd2, 16'h1234, "R9");

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R2", "reads left unanswered", exp_q.size(), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule